// File: doc/BRIEF.md
# CPU Clock Source Selector

This block decides which oscillator paces the processor and how fast. A fast main oscillator and a slow 32.768 kHz sub oscillator reach it as single-cycle tick pulses inside one system clock domain. From these ticks it makes a CPU clock-enable pulse train. On the main source the rate is either every main tick or every fourth main tick. On the sub source the rate is every second sub tick, whatever the divider setting.

Three small control registers drive it. The processor control register holds the divider bit and the main-oscillator stop request. The sub-oscillator mode register holds the sub stop bit and a feedback-resistor disable bit. The select register holds the requested source and a read-only flag showing the source that is actually in use.

A source change takes effect on the next tick of the new oscillator, and only once that oscillator runs. Until then the flag keeps showing the old source. The divider restarts at the switch, so no enable pulse comes early. The main oscillator can be stopped only while the processor runs from the sub clock.

Top module: `cpuclk_src_sel`

## Requirements
- R1: After a synchronous reset, the three read ports show processor control 02h, sub-oscillator mode 00h and select 00h. `cpu_on_sub` and all stop outputs are 0.
- R2: With the main source active, `cpu_clk_en` pulses once per main tick when processor control bit 1 is 0, and once per four main ticks when it is 1. Each pulse lasts one cycle and comes one system clock after the tick that completes the count.
- R3: Processor control bit 7 requests a main-oscillator stop and drives `main_osc_stop`. Writing 1 to it while `cpu_on_sub` is 0 leaves it unchanged. Writing 0 to it always takes effect.
- R4: With the sub source active, `cpu_clk_en` pulses once per two sub ticks, and processor control bit 1 has no effect.
- R5: Reserved bits read 0 whatever is written. Only bits 7 and 1 of processor control, bits 1 and 0 of sub-oscillator mode, and bit 4 of select can be written.
- R6: Select bit 4 requests the sub source (1) or the main source (0). Select bit 5 equals `cpu_on_sub`. It changes only on the first running tick of the requested source after the request, so right after the write it still shows the old source.
- R7: When the source changes, the divider restarts at the switching tick. The gap between the last enable before the switch and the first enable after it is never shorter than one full period of the new setting.
- R8: A request for an oscillator that is stopped stays pending. The switch happens on that oscillator's first tick after its stop bit is cleared. Ticks of a stopped oscillator are ignored.
- R9: Sub-oscillator mode bit 0 drives `sub_osc_stop`, and bit 1 drives `sub_fb_off`.
- R10: `wr_addr` selects 0 for processor control, 1 for sub-oscillator mode and 2 for select. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | One-cycle pulse per main oscillator edge |
| sub_tick | input | 1 | One-cycle pulse per sub oscillator edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| proc_rd | output | 8 | Processor control register contents |
| subosc_rd | output | 8 | Sub-oscillator mode register contents |
| select_rd | output | 8 | Select register with the active-source flag in bit 5 |
| cpu_clk_en | output | 1 | CPU clock-enable pulse |
| cpu_on_sub | output | 1 | 1 while the CPU actually runs from the sub source |
| main_osc_stop | output | 1 | Main oscillator stop control |
| sub_osc_stop | output | 1 | Sub oscillator stop control |
| sub_fb_off | output | 1 | Sub oscillator feedback resistor disable |

## Verification
Main ticks arrive every 3 cycles and sub ticks every 7, so the three enable gaps of 3, 12 and 14 cycles cannot be confused. The bench sweeps the divider bit under both sources. This separates a divider that acts on the wrong source from one that ignores the source entirely. Switches are made in both directions, toward a running and toward a stopped oscillator, with the smallest enable gap tracked across each switch. This tells a pending request apart from an early switch, and shows whether a short pulse appears. Writes of all-ones to each register, and the stop bit written from each source, separate masking faults from guard faults.

// File: rtl/cks_pkg.sv
package cks_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_PROC   = 2'd0;
    localparam logic [1:0] ADDR_SUBOSC = 2'd1;
    localparam logic [1:0] ADDR_SELECT = 2'd2;

    localparam int PROC_STOP_BIT = 7;
    localparam int PROC_DIV_BIT  = 1;
    localparam int SUB_STOP_BIT  = 0;
    localparam int SUB_FB_BIT    = 1;
    localparam int SEL_REQ_BIT   = 4;
    localparam int SEL_STAT_BIT  = 5;

    localparam logic [REG_W-1:0] PROC_MASK   = 8'h82;
    localparam logic [REG_W-1:0] SUBOSC_MASK = 8'h03;
    localparam logic [REG_W-1:0] SELECT_MASK = 8'h10;
    localparam logic [REG_W-1:0] PROC_RESET  = 8'h02;

    typedef enum logic {SRC_MAIN = 1'b0, SRC_SUB = 1'b1} clk_src_e;

    // Terminal count of the divider: ticks per enable minus one
    function automatic logic [1:0] div_limit(input clk_src_e src, input logic div4);
        if (src == SRC_SUB)
            return 2'd1;
        else if (div4)
            return 2'd3;
        else
            return 2'd0;
    endfunction
endpackage

// File: rtl/cks_regs.sv
module cks_regs
    import cks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             on_sub,
    output logic [REG_W-1:0] proc_q,
    output logic [REG_W-1:0] subosc_q,
    output logic [REG_W-1:0] select_q
);
    logic [REG_W-1:0] proc_wr;
    logic             stop_allowed;

    always_comb begin
        proc_wr      = wr_data & PROC_MASK;
        stop_allowed = on_sub || !wr_data[PROC_STOP_BIT];
        if (!stop_allowed)
            proc_wr[PROC_STOP_BIT] = proc_q[PROC_STOP_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            proc_q   <= PROC_RESET;
            subosc_q <= '0;
            select_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PROC:   proc_q   <= proc_wr;
                ADDR_SUBOSC: subosc_q <= wr_data & SUBOSC_MASK;
                ADDR_SELECT: select_q <= wr_data & SELECT_MASK;
                default: ;
            endcase
        end
    end

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ((proc_q & ~PROC_MASK) == '0) && ((subosc_q & ~SUBOSC_MASK) == '0)
        && ((select_q & ~SELECT_MASK) == '0));

    p_stop_only_on_sub_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(proc_q[PROC_STOP_BIT]) |-> $past(on_sub));
endmodule

// File: rtl/cks_switch.sv
module cks_switch
    import cks_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e req_src,
    input  logic     main_run_tick,
    input  logic     sub_run_tick,
    output clk_src_e act_src,
    output logic     switching
);
    always_comb begin
        if (req_src == SRC_SUB)
            switching = (act_src == SRC_MAIN) && sub_run_tick;
        else
            switching = (act_src == SRC_SUB) && main_run_tick;
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_src <= SRC_MAIN;
        else if (switching)
            act_src <= req_src;
    end

    p_to_sub_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_SUB && $past(act_src) == SRC_MAIN)
        |-> $past(sub_run_tick) && $past(req_src) == SRC_SUB);

    p_to_main_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (act_src == SRC_MAIN && $past(act_src) == SRC_SUB)
        |-> $past(main_run_tick) && $past(req_src) == SRC_MAIN);
endmodule

// File: rtl/cks_divider.sv
module cks_divider #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             en
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            en  <= 1'b0;
        end else if (restart) begin
            cnt <= '0;
            en  <= 1'b0;
        end else if (tick) begin
            if (cnt >= limit) begin
                cnt <= '0;
                en  <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
                en  <= 1'b0;
            end
        end else begin
            en <= 1'b0;
        end
    end

    p_en_follows_tick_r2: assert property (@(posedge clk) disable iff (rst)
        en |-> $past(tick) && !$past(restart));

    p_no_en_after_restart_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !en);
endmodule

// File: rtl/cpuclk_src_sel.sv
module cpuclk_src_sel
    import cks_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] proc_rd,
    output logic [7:0] subosc_rd,
    output logic [7:0] select_rd,
    output logic       cpu_clk_en,
    output logic       cpu_on_sub,
    output logic       main_osc_stop,
    output logic       sub_osc_stop,
    output logic       sub_fb_off
);
    logic [REG_W-1:0] proc_q, subosc_q, select_q;
    logic             main_run_tick, sub_run_tick, act_tick, switching;
    clk_src_e         req_src, act_src;
    logic [CNT_W-1:0] limit;

    cks_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .on_sub   (cpu_on_sub),
        .proc_q   (proc_q),
        .subosc_q (subosc_q),
        .select_q (select_q)
    );

    assign main_osc_stop = proc_q[PROC_STOP_BIT];
    assign sub_osc_stop  = subosc_q[SUB_STOP_BIT];
    assign sub_fb_off    = subosc_q[SUB_FB_BIT];
    assign main_run_tick = main_tick && !main_osc_stop;
    assign sub_run_tick  = sub_tick && !sub_osc_stop;
    assign req_src       = clk_src_e'(select_q[SEL_REQ_BIT]);

    cks_switch u_switch (
        .clk           (clk),
        .rst           (rst),
        .req_src       (req_src),
        .main_run_tick (main_run_tick),
        .sub_run_tick  (sub_run_tick),
        .act_src       (act_src),
        .switching     (switching)
    );

    assign cpu_on_sub = (act_src == SRC_SUB);
    assign act_tick   = cpu_on_sub ? sub_run_tick : main_run_tick;
    assign limit      = CNT_W'(div_limit(act_src, proc_q[PROC_DIV_BIT]));

    cks_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (act_tick),
        .restart (switching),
        .limit   (limit),
        .en      (cpu_clk_en)
    );

    always_comb begin
        proc_rd   = proc_q;
        subosc_rd = subosc_q;
        select_rd = select_q;
        select_rd[SEL_STAT_BIT] = cpu_on_sub;
    end

    p_main_runs_while_main_r3: assert property (@(posedge clk) disable iff (rst)
        !cpu_on_sub |-> !main_osc_stop);
endmodule

// File: tb/cpuclk_src_sel_test.sv
module cpuclk_src_sel_test;
    localparam int PM = 3;
    localparam int PS = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       main_tick = 1'b0, sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] proc_rd, subosc_rd, select_rd;
    logic       cpu_clk_en, cpu_on_sub, main_osc_stop, sub_osc_stop, sub_fb_off;

    int checks = 0, errors = 0;
    int gap_cnt = 0, min_gap = 1000000, max_gap = 0;
    bit have_prev = 0;

    cpuclk_src_sel uut (
        .clk(clk), .rst(rst), .main_tick(main_tick), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .proc_rd(proc_rd), .subosc_rd(subosc_rd), .select_rd(select_rd),
        .cpu_clk_en(cpu_clk_en), .cpu_on_sub(cpu_on_sub),
        .main_osc_stop(main_osc_stop), .sub_osc_stop(sub_osc_stop),
        .sub_fb_off(sub_fb_off)
    );

    always #10 clk = ~clk;

    // Oscillator tick generators
    initial begin
        int mc = 0, sc = 0;
        forever begin
            @(negedge clk);
            mc++; sc++;
            main_tick = (mc % PM == 0);
            sub_tick  = (sc % PS == 0);
        end
    end

    // Enable gap monitor
    initial begin
        forever begin
            @(negedge clk);
            gap_cnt++;
            if (cpu_clk_en) begin
                if (have_prev) begin
                    if (gap_cnt < min_gap) min_gap = gap_cnt;
                    if (gap_cnt > max_gap) max_gap = gap_cnt;
                end
                have_prev = 1;
                gap_cnt = 0;
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_stats();
        min_gap = 1000000; max_gap = 0;
    endtask

    task automatic steady_gap(input string req, input int exp);
        idle(60);
        clear_stats();
        idle(120);
        check(req, min_gap, exp);
        check(req, max_gap, exp);
    endtask

    initial begin
        idle(4);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check("R1 proc", proc_rd, 8'h02);
        check("R1 subosc", subosc_rd, 8'h00);
        check("R1 select", select_rd, 8'h00);
        check("R1 flags", {cpu_on_sub, main_osc_stop, sub_osc_stop, sub_fb_off}, 0);

        // R2 default main/4, then main/1
        steady_gap("R2 div4", 4 * PM);
        wr(2'd0, 8'h00);
        steady_gap("R2 div1", PM);

        // R3 and R5: all-ones while main active: stop ignored, reserved masked
        wr(2'd0, 8'hFF);
        check("R3 R5 proc", proc_rd, 8'h02);
        check("R3 stop out", main_osc_stop, 0);
        steady_gap("R3 still div4", 4 * PM);

        // R10 address 3 ignored
        wr(2'd3, 8'hFF);
        check("R10 proc", proc_rd, 8'h02);
        check("R10 subosc", subosc_rd, 8'h00);
        check("R10 select", select_rd, 8'h00);

        // R6/R7 switch to sub; flag lags
        clear_stats();
        wr(2'd2, 8'hFF);
        check("R6 lag", select_rd, 8'h10);
        check("R5 select", select_rd & 8'hCF, 8'h00);
        idle(2 * PS);
        check("R6 on sub", cpu_on_sub, 1);
        check("R6 select", select_rd, 8'h30);
        idle(40);
        check("R7 min gap", (min_gap >= 2 * PS) ? 1 : 0, 1);

        // R4 sub/2 regardless of divider bit
        steady_gap("R4 div4", 2 * PS);
        wr(2'd0, 8'h00);
        steady_gap("R4 div1", 2 * PS);

        // R3 stop allowed on sub
        wr(2'd0, 8'h80);
        check("R3 proc", proc_rd, 8'h80);
        check("R3 stop out", main_osc_stop, 1);
        steady_gap("R3 sub keeps", 2 * PS);

        // R8 request main while stopped: pending
        wr(2'd2, 8'h00);
        idle(100);
        check("R8 pending", cpu_on_sub, 1);
        check("R8 select", select_rd, 8'h20);
        clear_stats();
        wr(2'd0, 8'h00);
        check("R3 clear", main_osc_stop, 0);
        idle(2 * PM + 2);
        check("R8 released", cpu_on_sub, 0);
        idle(40);
        check("R7 min gap to main", (min_gap >= PM) ? 1 : 0, 1);
        steady_gap("R2 div1 back", PM);

        // R9 and R5 sub oscillator mode register
        wr(2'd1, 8'hFF);
        check("R9 R5 subosc", subosc_rd, 8'h03);
        check("R9 outs", {sub_osc_stop, sub_fb_off}, 2'b11);
        wr(2'd1, 8'h02);
        check("R9 fb only", {sub_osc_stop, sub_fb_off}, 2'b01);
        wr(2'd1, 8'h01);

        // R8 request sub while sub stopped
        wr(2'd2, 8'h10);
        idle(100);
        check("R8 sub pending", cpu_on_sub, 0);
        steady_gap("R8 main keeps", PM);
        wr(2'd1, 8'h00);
        idle(2 * PS + 2);
        check("R8 sub released", cpu_on_sub, 1);
        steady_gap("R4 after release", 2 * PS);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule